// File: doc/BRIEF.md
# Power-Down Aware Burst Launch Scheduler

This block sits on the master side of a ping-pong line transceiver and decides in which 8 kHz frame, and at which instant, the transmitter sends its burst. It watches three things: an active-low power-down control, a frame reference strobe that rises once per frame, and a pulse from the receiver saying that an incoming reply from the far end has just ended. It drives a one-cycle launch pulse, a burst window that is high for as long as the burst lasts, a bit-cadence strobe inside that window, the burst format chosen at launch, and a low-power flag.

While power-down is held, the transmitter stays quiet. The receive path is not touched by this block and keeps running. When power-down is released, the scheduler does not launch at once. It waits until it has counted a set number of frame-reference rising edges (three by default) or until a far-end reply ends, whichever comes first. It then launches on the next frame-reference rising edge, and after that on every one. A burst is either short (10 bit periods by default) or long (20 bit periods), chosen by a mode input that is read at the moment of launch. Pulling power-down low again sends the block straight back to idle and clears its edge count. A burst that has already started always runs to its end.

Top module: `burst_sched`

## Requirements
- R1: During and right after reset, low_power is 1, and tx_start, tx_active and tx_bit_stb are 0.
- R2: While pd_n is 0, no tx_start is produced and low_power stays 1, whatever msi does.
- R3: low_power drops to 0 one clock after pd_n rises. If rx_done stays 0, the first tx_start follows the (WAKE_EDGES+1)-th msi rising edge after that, and none follows the earlier ones.
- R4: An rx_done pulse seen while waiting ends the wait at once. The first tx_start then follows the next msi rising edge after the rx_done cycle.
- R5: Once bursts are running, every msi rising edge produces a one-cycle tx_start. Counted from the first cycle in which msi is high, it appears SYNC_STAGES+1 clocks later.
- R6: tx_active goes high in the tx_start cycle. It stays high for SHORT_BITS*CYC_PER_BIT cycles when mode_long was 0 at launch, and for LONG_BITS*CYC_PER_BIT cycles when mode_long was 1. tx_long shows the mode that was captured.
- R7: A change of mode_long during a burst changes neither the burst length nor tx_long. The new mode applies from the next launch.
- R8: When pd_n falls, low_power is 1 in the next cycle and no further tx_start follows. A burst already under way still runs its full length.
- R9: The count of msi edges restarts from zero each time pd_n goes low. Edges counted before a power-down do not shorten the next wait.
- R10: tx_bit_stb is high in the first cycle of each bit period of a burst, so one burst gives SHORT_BITS or LONG_BITS strobes.
- R11: An msi rising edge that comes while a burst is still active starts no new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down control, active low, synchronous to clk |
| msi | input | 1 | Frame reference; each rising edge marks a frame start (synchronised inside) |
| rx_done | input | 1 | One-cycle pulse: an incoming far-end reply has ended |
| mode_long | input | 1 | Burst format select: 0 short, 1 long |
| tx_start | output | 1 | One-cycle burst launch pulse |
| tx_active | output | 1 | High for the whole duration of the current burst |
| tx_bit_stb | output | 1 | First cycle of each bit period within the burst |
| tx_long | output | 1 | Format captured at launch for the running burst |
| low_power | output | 1 | High while the scheduler is powered down |

## Verification
The assertions assume that pd_n and rx_done are already synchronous to clk and that msi stays low for at least one clock between rising edges. They also assume that a frame is longer than a long burst plus the synchroniser delay, except where R11 is tested on purpose. The bench changes every input on the falling clock edge and keeps msi high and low for 60 cycles each, a 120-cycle frame that is well above the 40-cycle long burst. The only exception is one deliberate two-cycle dip of msi inside a burst. The bench raises rx_done and pd_n far away from any msi edge, so the order of events in every scenario is clear.

// File: rtl/bsch_pkg.sv
package bsch_pkg;

   typedef enum logic [1:0] {
      ST_DOWN = 2'd0,
      ST_WAKE = 2'd1,
      ST_ARM  = 2'd2,
      ST_RUN  = 2'd3
   } bsch_state_e;

   function automatic int burst_cycles(input int bits, input int cyc_per_bit);
      return bits * cyc_per_bit;
   endfunction

   function automatic int cnt_width(input int max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/bsch_msi_edge.sv
module bsch_msi_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic msi,
   output logic msi_rise
);

   logic msi_s;
   logic msi_prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign msi_s = msi;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= msi;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign msi_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msi_prev_q <= 1'b0;
      else        msi_prev_q <= msi_s;
   end

   assign msi_rise = msi_s & ~msi_prev_q;

endmodule

// File: rtl/bsch_wake_cnt.sv
module bsch_wake_cnt #(
   parameter int WAKE_EDGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);
   import bsch_pkg::*;

   localparam int CW = cnt_width(WAKE_EDGES);
   localparam logic [CW-1:0] LIMIT = CW'(WAKE_EDGES);

   logic [CW-1:0] cnt_q;

   assign full = (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && !full) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bsch_burst_tmr.sv
module bsch_burst_tmr #(
   parameter int SHORT_BITS  = 10,
   parameter int LONG_BITS   = 20,
   parameter int CYC_PER_BIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic mode_long,
   output logic active,
   output logic bit_stb,
   output logic long_fmt
);
   import bsch_pkg::*;

   localparam int LEN_S = burst_cycles(SHORT_BITS, CYC_PER_BIT);
   localparam int LEN_L = burst_cycles(LONG_BITS, CYC_PER_BIT);
   localparam int TW    = cnt_width(LEN_L);
   localparam logic [TW-1:0] LOAD_S = TW'(LEN_S - 1);
   localparam logic [TW-1:0] LOAD_L = TW'(LEN_L - 1);

   logic [TW-1:0] cnt_q;
   logic          act_q;
   logic          long_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         act_q  <= 1'b0;
         long_q <= 1'b0;
      end else if (launch) begin
         cnt_q  <= mode_long ? LOAD_L : LOAD_S;
         act_q  <= 1'b1;
         long_q <= mode_long;
      end else if (act_q) begin
         if (cnt_q == '0) act_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   generate
      if (CYC_PER_BIT == 1) begin : g_stb_every
         assign bit_stb = act_q;
      end else begin : g_stb_phase
         localparam int PW = $clog2(CYC_PER_BIT);
         localparam logic [PW-1:0] PH_LAST = PW'(CYC_PER_BIT - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q <= '0;
            end else if (launch) begin
               ph_q <= '0;
            end else if (act_q) begin
               ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            end
         end
         assign bit_stb = act_q && (ph_q == '0);
      end
   endgenerate

   assign active   = act_q;
   assign long_fmt = long_q;

endmodule

// File: rtl/burst_sched.sv
module burst_sched #(
   parameter int SHORT_BITS  = 10,
   parameter int LONG_BITS   = 20,
   parameter int CYC_PER_BIT = 2,
   parameter int WAKE_EDGES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic msi,
   input  logic rx_done,
   input  logic mode_long,
   output logic tx_start,
   output logic tx_active,
   output logic tx_bit_stb,
   output logic tx_long,
   output logic low_power
);
   import bsch_pkg::*;

   generate
      if (SHORT_BITS < 1 || LONG_BITS < SHORT_BITS || CYC_PER_BIT < 1 ||
          WAKE_EDGES < 1 || SYNC_STAGES < 0) begin : g_bad_cfg
         $error("burst_sched: illegal parameter set");
      end
   endgenerate

   bsch_state_e st_q, st_d;
   logic        msi_rise;
   logic        wake_full;
   logic        wake_clr;
   logic        wake_inc;
   logic        launch;
   logic        start_q;

   bsch_msi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .msi      (msi),
      .msi_rise (msi_rise)
   );

   assign wake_clr = !pd_n || (st_q != ST_WAKE);
   assign wake_inc = msi_rise && (st_q == ST_WAKE);

   bsch_wake_cnt #(.WAKE_EDGES(WAKE_EDGES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wake_clr),
      .inc   (wake_inc),
      .full  (wake_full)
   );

   always_comb begin
      st_d   = st_q;
      launch = 1'b0;
      if (!pd_n) begin
         st_d = ST_DOWN;
      end else begin
         case (st_q)
            ST_DOWN: st_d = ST_WAKE;
            ST_WAKE: if (rx_done || wake_full) st_d = ST_ARM;
            ST_ARM: if (msi_rise) begin
               launch = !tx_active;
               st_d   = ST_RUN;
            end
            ST_RUN:  launch = msi_rise && !tx_active;
            default: st_d = ST_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_DOWN;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= launch;
      end
   end

   bsch_burst_tmr #(
      .SHORT_BITS  (SHORT_BITS),
      .LONG_BITS   (LONG_BITS),
      .CYC_PER_BIT (CYC_PER_BIT)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .mode_long (mode_long),
      .active    (tx_active),
      .bit_stb   (tx_bit_stb),
      .long_fmt  (tx_long)
   );

   assign tx_start  = start_q;
   assign low_power = (st_q == ST_DOWN);

endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk #(
   parameter int SHORT_BITS  = 10,
   parameter int LONG_BITS   = 20,
   parameter int CYC_PER_BIT = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pd_n,
   input logic tx_start,
   input logic tx_active,
   input logic tx_bit_stb,
   input logic tx_long,
   input logic low_power
);

   localparam logic [31:0] LEN_S = 32'(SHORT_BITS * CYC_PER_BIT);
   localparam logic [31:0] LEN_L = 32'(LONG_BITS * CYC_PER_BIT);

   logic [31:0] run_q;
   logic [31:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         exp_q <= '0;
      end else if (tx_start) begin
         run_q <= 32'd1;
         exp_q <= tx_long ? LEN_L : LEN_S;
      end else if (tx_active) begin
         run_q <= run_q + 32'd1;
      end
   end

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);                                   // R5
   AST_DOWN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> !tx_start);                                      // R2
   AST_DOWN_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> low_power);                                      // R8
   AST_WAKE_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(low_power) |-> !tx_start);                           // R3
   AST_START_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> tx_active);                                   // R6
   AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_active) |-> (run_q == exp_q));                    // R6
   AST_FORMAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && !tx_start) |-> $stable(tx_long));            // R7
   AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_stb |-> tx_active);                                 // R10
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !$past(tx_active));                           // R11

endmodule

bind burst_sched burst_sched_chk #(
   .SHORT_BITS  (SHORT_BITS),
   .LONG_BITS   (LONG_BITS),
   .CYC_PER_BIT (CYC_PER_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_n       (pd_n),
   .tx_start   (tx_start),
   .tx_active  (tx_active),
   .tx_bit_stb (tx_bit_stb),
   .tx_long    (tx_long),
   .low_power  (low_power)
);

// File: tb/sim_burst_sched.sv
`timescale 1ns/1ps
module sim_burst_sched;

   localparam int CLK_PERIOD = 10;
   localparam int SHORT_BITS = 10;
   localparam int LONG_BITS  = 20;
   localparam int CPB        = 2;
   localparam int WAKE_N     = 3;
   localparam int SYNC_N     = 2;
   localparam int FRAME      = 120;
   localparam int LAT        = SYNC_N + 1;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b0;
   logic msi = 1'b0;
   logic rx_done = 1'b0;
   logic mode_long = 1'b0;
   logic tx_start, tx_active, tx_bit_stb, tx_long, low_power;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int cyc = 0;
   int n_start = 0;
   int last_start_cyc = -1;
   int run_len = 0;
   int run_stb = 0;
   int last_len = 0;
   int last_stb = 0;
   int last_long = 0;
   bit act_prev = 1'b0;
   int c_raise = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_sched #(
      .SHORT_BITS  (SHORT_BITS),
      .LONG_BITS   (LONG_BITS),
      .CYC_PER_BIT (CPB),
      .WAKE_EDGES  (WAKE_N),
      .SYNC_STAGES (SYNC_N)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .msi        (msi),
      .rx_done    (rx_done),
      .mode_long  (mode_long),
      .tx_start   (tx_start),
      .tx_active  (tx_active),
      .tx_bit_stb (tx_bit_stb),
      .tx_long    (tx_long),
      .low_power  (low_power)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      act_prev <= tx_active;
      if (tx_start) begin
         n_start <= n_start + 1;
         last_start_cyc <= cyc;
         run_len <= 1;
         run_stb <= tx_bit_stb ? 1 : 0;
         last_long <= tx_long ? 1 : 0;
      end else if (tx_active) begin
         run_len <= run_len + 1;
         run_stb <= run_stb + (tx_bit_stb ? 1 : 0);
      end else if (act_prev) begin
         last_len <= run_len;
         last_stb <= run_stb;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic frame(input int drop_at, input int flip_at, input int dip_at);
      @(negedge clk);
      msi = 1'b1;
      c_raise = cyc;
      for (int i = 1; i < FRAME; i++) begin
         @(negedge clk);
         if (drop_at > 0 && i == drop_at + 1)
            chk(low_power == 1'b1, "R8 low_power after pd_n fall", int'(low_power), 1);
         if (i == FRAME/2) msi = 1'b0;
         if (i == drop_at) pd_n = 1'b0;
         if (i == flip_at) mode_long = ~mode_long;
         if (i == dip_at) msi = 1'b0;
         if (i == dip_at + 2) msi = 1'b1;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(low_power == 1'b1, "R1 low_power in reset", int'(low_power), 1);
      chk(!tx_start && !tx_active && !tx_bit_stb, "R1 outputs quiet in reset",
          int'({tx_start, tx_active, tx_bit_stb}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(low_power == 1'b1 && !tx_active, "R1 state after reset release",
          int'({low_power, tx_active}), 2);
   endtask

   task automatic t_down();
      int n0 = n_start;
      frame(-1, -1, -100);
      frame(-1, -1, -100);
      chk(n_start == n0, "R2 no launch while pd_n low", n_start, n0);
      chk(low_power == 1'b1, "R2 low_power held", int'(low_power), 1);
   endtask

   task automatic t_wake();
      int n0;
      mode_long = 1'b0;
      @(negedge clk);
      pd_n = 1'b1;
      @(negedge clk);
      chk(low_power == 1'b0, "R3 low_power clears", int'(low_power), 0);
      n0 = n_start;
      for (int k = 0; k < WAKE_N; k++) frame(-1, -1, -100);
      chk(n_start == n0, "R3 no launch during wait edges", n_start, n0);
      frame(-1, -1, -100);
      chk(n_start == n0 + 1, "R3 launch after wait", n_start, n0 + 1);
      chk(last_start_cyc == c_raise + LAT, "R3 launch cycle", last_start_cyc, c_raise + LAT);
      chk(last_len == SHORT_BITS * CPB, "R6 short burst length", last_len, SHORT_BITS * CPB);
      chk(last_long == 0, "R6 short format flag", last_long, 0);
      chk(last_stb == SHORT_BITS, "R10 short bit strobes", last_stb, SHORT_BITS);
   endtask

   task automatic t_run();
      int n0;
      mode_long = 1'b1;
      n0 = n_start;
      frame(-1, -1, -100);
      chk(n_start == n0 + 1, "R5 launch per frame", n_start, n0 + 1);
      chk(last_start_cyc == c_raise + LAT, "R5 launch latency", last_start_cyc, c_raise + LAT);
      chk(last_len == LONG_BITS * CPB, "R6 long burst length", last_len, LONG_BITS * CPB);
      chk(last_long == 1, "R6 long format flag", last_long, 1);
      chk(last_stb == LONG_BITS, "R10 long bit strobes", last_stb, LONG_BITS);
      frame(-1, -1, -100);
      chk(n_start == n0 + 2, "R5 second frame launch", n_start, n0 + 2);
   endtask

   task automatic t_flip();
      frame(-1, 10, -100);
      chk(last_len == LONG_BITS * CPB, "R7 length kept after mode flip", last_len, LONG_BITS * CPB);
      chk(last_long == 1, "R7 format kept after mode flip", last_long, 1);
      frame(-1, -1, -100);
      chk(last_len == SHORT_BITS * CPB, "R7 new mode on next launch", last_len, SHORT_BITS * CPB);
      mode_long = 1'b1;
   endtask

   task automatic t_overlap();
      int n0 = n_start;
      frame(-1, -1, 10);
      chk(n_start == n0 + 1, "R11 edge inside burst ignored", n_start, n0 + 1);
      chk(last_len == LONG_BITS * CPB, "R11 burst unchanged", last_len, LONG_BITS * CPB);
   endtask

   task automatic t_pd_mid();
      int n0 = n_start;
      frame(10, -1, -100);
      chk(n_start == n0 + 1, "R8 burst before drop launched", n_start, n0 + 1);
      chk(last_len == LONG_BITS * CPB, "R8 burst finishes after drop", last_len, LONG_BITS * CPB);
      frame(-1, -1, -100);
      chk(n_start == n0 + 1, "R8 no launch after drop", n_start, n0 + 1);
   endtask

   task automatic t_rx();
      int n0;
      @(negedge clk);
      pd_n = 1'b1;
      n0 = n_start;
      frame(-1, -1, -100);
      chk(n_start == n0, "R4 no launch before rx_done", n_start, n0);
      @(negedge clk);
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      repeat (4) @(negedge clk);
      frame(-1, -1, -100);
      chk(n_start == n0 + 1, "R4 launch after rx_done", n_start, n0 + 1);
      chk(last_start_cyc == c_raise + LAT, "R4 launch cycle", last_start_cyc, c_raise + LAT);
   endtask

   task automatic t_restart();
      int n0;
      @(negedge clk);
      pd_n = 1'b0;
      repeat (4) @(negedge clk);
      pd_n = 1'b1;
      frame(-1, -1, -100);
      frame(-1, -1, -100);
      @(negedge clk);
      pd_n = 1'b0;
      repeat (4) @(negedge clk);
      pd_n = 1'b1;
      n0 = n_start;
      for (int k = 0; k < WAKE_N; k++) frame(-1, -1, -100);
      chk(n_start == n0, "R9 count restarted after power-down", n_start, n0);
      frame(-1, -1, -100);
      chk(n_start == n0 + 1, "R9 launch after full new wait", n_start, n0 + 1);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_down();
      t_wake();
      t_run();
      t_flip();
      t_overlap();
      t_pd_mid();
      t_rx();
      t_restart();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule